// File: doc/BRIEF.md
# Address-Latched Cartridge Bank Controller

This block switches banks for a cartridge on an 8-bit console. It watches the CPU bus, and any write into the upper half of the CPU address space loads a single configuration register. The write address supplies almost all of the fields. Only the two lowest data bits are used, and they complete the character bank number. From the register, the block forms three things: a physical program ROM address, a physical character ROM address, and the nametable RAM address bit that sets the mirroring.

The program ROM is built from up to four chip slots, and slot 2 is empty. The three populated slots are packed end to end in the order 0, 1, 3, so slot 3 takes linear index 2. While slot 2 is selected, the program output-enable stays low for every read of the ROM area, and the data bus then floats to its open-bus value.

The block has no data stream, so it has no valid/ready handshake and no back-pressure. Every pin is a plain control or address signal. The address outputs are combinational from the latched register and the current bus address. A write takes effect on the clock edge where it is sampled, and the new mapping is visible from the next cycle on.

Top module: `cbc_bank_ctrl`

## Requirements
- R1: The register loads on a rising clock edge where `cpu_wr`, `cpu_rom_sel` and `cpu_addr[15]` are all high. A write with `cpu_rom_sel` low, or with `cpu_addr[15]` low, leaves every output mapping unchanged.
- R2: Data bits D7..D2 and address bit A4 of a loading write have no effect on any output.
- R3: Address bit A13 of the write sets the mirroring. With 0 (vertical), `mirror_h`=0 and `nt_a10`=`ppu_addr[10]`. With 1 (horizontal), `mirror_h`=1 and `nt_a10`=`ppu_addr[11]`.
- R4: Address bits A12..A11 select a chip slot, which is remapped as 0→0, 1→1, 3→2. The 16 KB page number is (remapped slot × 32) + A10..A6, so it never exceeds 95.
- R5: With A5=0 (32 KB mode), the window at `cpu_addr[14]`=0 uses the page with bit 0 cleared, and the window at `cpu_addr[14]`=1 uses that even page plus one.
- R6: With A5=1 (16 KB mode), both windows use the page unchanged.
- R7: `prg_rom_addr` = {window page (7 bits), `cpu_addr[13:0]`}.
- R8: The character bank is (A3..A0 × 4) + D1..D0, and `chr_rom_addr` = {bank (6 bits), `ppu_addr[12:0]`}.
- R9: `prg_oe` is high only when `cpu_rom_sel`=1, `cpu_wr`=0, `cpu_addr[15]`=1 and the latched slot is not 2.
- R10: Reset gives the state of a write of 0 to 0x8000: slot 0, 32 KB mode with pages 0 and 1, character bank 0, vertical mirroring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rom_sel | input | 1 | ROM-area select from the console |
| ppu_addr | input | 14 | Video bus address |
| prg_rom_addr | output | 21 | Physical program ROM address |
| prg_oe | output | 1 | Program ROM output-enable |
| chr_rom_addr | output | 19 | Physical character ROM address |
| nt_a10 | output | 1 | Nametable RAM address bit 10 |
| mirror_h | output | 1 | Latched mirroring, 1 = horizontal |

## Verification
A single loading write changes the program mapping, the character bank and the mirroring in the same clock edge. The bench provokes this with addresses that set the mode bit, the slot field, A13 and the character bits together, including a write whose data also carries noise in D7..D2. In the next cycle it probes both program windows and two video addresses, and compares each output against a reference model kept in the bench. A selection of slot 2 is judged in the same way, so the bench confirms that the output-enable drops while the character mapping from that same write still applies.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  // Field layout of the write address; the positions are behaviour.
  localparam int CHIP_W    = 2;
  localparam int PAGE_W    = 5;
  localparam int CHR_HI_W  = 4;
  localparam int CHR_LO_W  = 2;
  localparam int MIR_BIT   = 13;
  localparam int CHIP_LSB  = 11;
  localparam int PAGE_LSB  = 6;
  localparam int MODE_BIT  = 5;
  localparam int CHR_LSB   = 0;
  localparam int PG_W      = CHIP_W + PAGE_W;
  localparam int CHR_W     = CHR_HI_W + CHR_LO_W;
  localparam int WIN_OFF_W = 14;
  localparam int CHR_OFF_W = 13;

  typedef struct packed {
    logic                mirror_h;
    logic [CHIP_W-1:0]   chip;
    logic [PAGE_W-1:0]   page;
    logic                half;
    logic [CHR_HI_W-1:0] chr_hi;
    logic [CHR_LO_W-1:0] chr_lo;
  } cbc_cfg_t;

  function automatic cbc_cfg_t cbc_decode(input logic [15:0] a, input logic [CHR_LO_W-1:0] d);
    cbc_cfg_t c;
    c.mirror_h = a[MIR_BIT];
    c.chip     = a[CHIP_LSB +: CHIP_W];
    c.page     = a[PAGE_LSB +: PAGE_W];
    c.half     = a[MODE_BIT];
    c.chr_hi   = a[CHR_LSB +: CHR_HI_W];
    c.chr_lo   = d;
    return c;
  endfunction
endpackage

// File: rtl/cbc_cfg_reg.sv
module cbc_cfg_reg
  import cbc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [15:0]         cpu_addr,
  input  logic [CHR_LO_W-1:0] cpu_data_lo,
  input  logic                cpu_wr,
  input  logic                cpu_rom_sel,
  output cbc_cfg_t            cfg_q
);
  localparam cbc_cfg_t RESET_CFG = cbc_decode(16'h8000, '0);

  logic load;
  assign load = cpu_wr & cpu_rom_sel & cpu_addr[15];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= RESET_CFG;
    else if (load) cfg_q <= cbc_decode(cpu_addr, cpu_data_lo);
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_q)); // R1
  AST_LOAD_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cfg_q.mirror_h == $past(cpu_addr[MIR_BIT])); // R3
  AST_LOAD_CHR_LO: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cfg_q.chr_lo == $past(cpu_data_lo)); // R8
endmodule

// File: rtl/cbc_prg_map.sv
module cbc_prg_map
  import cbc_pkg::*;
#(
  parameter int ABSENT_SLOT = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  cbc_cfg_t                  cfg,
  input  logic [WIN_OFF_W:0]        cpu_off,
  input  logic                      rom_read,
  output logic [PG_W+WIN_OFF_W-1:0] prg_rom_addr,
  output logic                      prg_oe
);
  localparam int NUM_SLOTS = 1 << CHIP_W;
  localparam int MAX_PAGE  = (NUM_SLOTS - 1) * (1 << PAGE_W) - 1;

  logic [CHIP_W-1:0] lin_idx;
  logic              present;
  logic [PG_W-1:0]   page_full, win_lo, win_hi, win_sel;

  generate
    if (ABSENT_SLOT < NUM_SLOTS) begin : g_sparse
      assign present = (cfg.chip != CHIP_W'(ABSENT_SLOT));
      assign lin_idx = (cfg.chip > CHIP_W'(ABSENT_SLOT)) ? cfg.chip - CHIP_W'(1) : cfg.chip;
    end else begin : g_dense
      assign present = 1'b1;
      assign lin_idx = cfg.chip;
    end
  endgenerate

  assign page_full = {lin_idx, cfg.page};
  always_comb begin
    if (cfg.half) begin
      win_lo = page_full;
      win_hi = page_full;
    end else begin
      win_lo = {page_full[PG_W-1:1], 1'b0};
      win_hi = {page_full[PG_W-1:1], 1'b1};
    end
  end

  assign win_sel      = cpu_off[WIN_OFF_W] ? win_hi : win_lo;
  assign prg_rom_addr = {win_sel, cpu_off[WIN_OFF_W-1:0]};
  assign prg_oe       = rom_read & present;

  AST_PAIR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.half |-> (win_lo[0] == 1'b0 && win_hi == win_lo + PG_W'(1))); // R5
  AST_HALF_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.half |-> win_lo == win_hi); // R6
  AST_ABSENT_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (ABSENT_SLOT < NUM_SLOTS && cfg.chip == CHIP_W'(ABSENT_SLOT)) |-> !prg_oe); // R9
  AST_PAGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    present |-> int'(page_full) <= MAX_PAGE); // R4
endmodule

// File: rtl/cbc_chr_map.sv
module cbc_chr_map
  import cbc_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  cbc_cfg_t                   cfg,
  input  logic [CHR_OFF_W-1:0]       ppu_off,
  output logic [CHR_W+CHR_OFF_W-1:0] chr_rom_addr,
  output logic                       nt_a10
);
  assign chr_rom_addr = {cfg.chr_hi, cfg.chr_lo, ppu_off};
  assign nt_a10       = cfg.mirror_h ? ppu_off[11] : ppu_off[10];

  AST_NT_VERT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.mirror_h && $stable(ppu_off[10]) && $stable(cfg)) |-> $stable(nt_a10)); // R3
endmodule

// File: rtl/cbc_bank_ctrl.sv
module cbc_bank_ctrl
  import cbc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_data,
  input  logic        cpu_wr,
  input  logic        cpu_rom_sel,
  input  logic [13:0] ppu_addr,
  output logic [20:0] prg_rom_addr,
  output logic        prg_oe,
  output logic [18:0] chr_rom_addr,
  output logic        nt_a10,
  output logic        mirror_h
);
  cbc_cfg_t cfg;
  logic     rom_read;
  logic     unused_bits;

  assign unused_bits = ^{cpu_data[7:CHR_LO_W], cpu_addr[4], ppu_addr[13]};
  assign rom_read    = cpu_rom_sel & ~cpu_wr & cpu_addr[15];
  assign mirror_h    = cfg.mirror_h;

  cbc_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr),
    .cpu_data_lo(cpu_data[CHR_LO_W-1:0]), .cpu_wr(cpu_wr),
    .cpu_rom_sel(cpu_rom_sel), .cfg_q(cfg)
  );

  cbc_prg_map #(.ABSENT_SLOT(2)) u_prg (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .cpu_off(cpu_addr[WIN_OFF_W:0]),
    .rom_read(rom_read), .prg_rom_addr(prg_rom_addr), .prg_oe(prg_oe)
  );

  cbc_chr_map u_chr (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .ppu_off(ppu_addr[CHR_OFF_W-1:0]),
    .chr_rom_addr(chr_rom_addr), .nt_a10(nt_a10)
  );

  AST_NO_OE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |-> !prg_oe); // R9
endmodule

// File: tb/cbc_bank_ctrl_tb.sv
`timescale 1ns/1ps
module cbc_bank_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic cpu_wr = 1'b0, cpu_rom_sel = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic [20:0] prg_rom_addr;
  logic prg_oe;
  logic [18:0] chr_rom_addr;
  logic nt_a10, mirror_h;

  always #2.5 clk = ~clk;

  cbc_bank_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .cpu_rom_sel(cpu_rom_sel), .ppu_addr(ppu_addr),
    .prg_rom_addr(prg_rom_addr), .prg_oe(prg_oe), .chr_rom_addr(chr_rom_addr),
    .nt_a10(nt_a10), .mirror_h(mirror_h)
  );

  typedef struct {
    string       req;
    logic [20:0] prg;
    logic        oe;
    logic [18:0] chr;
    logic        nt;
    logic        mh;
  } exp_t;

  exp_t exp_q[$];
  event ev_probe;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  // reference model state
  logic       m_mh, m_half;
  logic [1:0] m_chip;
  logic [4:0] m_pg;
  logic [5:0] m_chr;

  task automatic model_reset();
    m_mh = 1'b0; m_half = 1'b0; m_chip = 2'd0; m_pg = 5'd0; m_chr = 6'd0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d, input logic sel);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = 1'b1; cpu_rom_sel = sel;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rom_sel = 1'b0; cpu_data = 8'h00;
    if (sel && a[15]) begin
      m_mh = a[13]; m_chip = a[12:11]; m_pg = a[10:6]; m_half = a[5];
      m_chr = {a[3:0], d[1:0]};
    end
  endtask

  task automatic probe(input logic [15:0] a, input logic sel, input logic [13:0] p, input string req);
    exp_t e;
    logic [6:0] pg, w;
    logic [1:0] lin;
    lin = (m_chip == 2'd3) ? 2'd2 : m_chip;
    pg  = {lin, m_pg};
    if (m_half) w = pg;
    else        w = a[14] ? {pg[6:1], 1'b1} : {pg[6:1], 1'b0};
    e.req = req;
    e.prg = {w, a[13:0]};
    e.oe  = sel && a[15] && (m_chip != 2'd2);
    e.chr = {m_chr, p[12:0]};
    e.nt  = m_mh ? p[11] : p[10];
    e.mh  = m_mh;
    @(negedge clk);
    cpu_addr = a; cpu_rom_sel = sel; cpu_wr = 1'b0; ppu_addr = p;
    exp_q.push_back(e);
    -> ev_probe;
  endtask

  task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(ev_probe);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        cmp(e.req, "prg_rom_addr", 32'(prg_rom_addr), 32'(e.prg));
        cmp(e.req, "prg_oe", 32'(prg_oe), 32'(e.oe));
        cmp(e.req, "chr_rom_addr", 32'(chr_rom_addr), 32'(e.chr));
        cmp(e.req, "nt_a10", 32'(nt_a10), 32'(e.nt));
        cmp(e.req, "mirror_h", 32'(mirror_h), 32'(e.mh));
      end
    end
  end

  task automatic probe_all(input string req);
    probe(16'h8123, 1'b1, 14'h0400, req);
    probe(16'hC3FF, 1'b1, 14'h0800, req);
    probe(16'hFFFF, 1'b1, 14'h1C55, req);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    probe_all("R10");                        // reset: pages 0/1, chr 0, vertical
    cpu_write(16'h80C0, 8'h00, 1'b1); probe_all("R5");   // 32 KB pair 2/3
    cpu_write(16'h8140, 8'h00, 1'b1); probe_all("R5");   // pair 4/5
    cpu_write(16'h8120, 8'h00, 1'b1); probe_all("R6");   // 16 KB page 4
    cpu_write(16'h81E0, 8'h00, 1'b1); probe_all("R6");   // 16 KB page 7
    cpu_write(16'h8820, 8'h00, 1'b1); probe_all("R4");   // slot 1 -> 32
    cpu_write(16'h9820, 8'h00, 1'b1); probe_all("R4");   // slot 3 -> 64
    cpu_write(16'hBFDF, 8'h00, 1'b1); probe_all("R4");   // slot 3 top: page 95 pair
    cpu_write(16'h9020, 8'h00, 1'b1); probe_all("R9");   // absent slot
    probe(16'h8000, 1'b0, 14'h0000, "R9");               // rom_sel low
    cpu_write(16'h800F, 8'h02, 1'b1); probe_all("R8");   // chr 62
    cpu_write(16'h8000, 8'h03, 1'b1); probe_all("R8");   // chr 3
    cpu_write(16'hA000, 8'h00, 1'b1); probe_all("R3");   // horizontal
    cpu_write(16'h8000, 8'h00, 1'b1); probe_all("R3");   // vertical again
    cpu_write(16'hAA21, 8'h03, 1'b1); probe_all("R7");   // combined fields
    cpu_write(16'h8015, 8'hFE, 1'b1); probe_all("R2");   // A4 and D7..D2 noise
    cpu_write(16'hB5A7, 8'h01, 1'b0); probe_all("R1");   // rom_sel low: ignored
    cpu_write(16'h3FFF, 8'h03, 1'b1); probe_all("R1");   // below 0x8000: ignored
    @(negedge clk); cpu_wr = 1'b1; cpu_rom_sel = 1'b1; cpu_addr = 16'h9000;
    #1; cmp("R9", "prg_oe during write", 32'(prg_oe), 32'd0);
    @(negedge clk); cpu_wr = 1'b0; cpu_rom_sel = 1'b0;
    m_mh = 1'b0; m_chip = 2'd2; m_pg = 5'd0; m_half = 1'b0; m_chr = 6'd0;
    probe_all("R9");
    cpu_write(16'hB9E9, 8'h02, 1'b1);
    do_reset(); probe_all("R10");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule